// File: doc/BRIEF.md
# Vertical Cascade Priority Chain Node

This block is the per-device cascade logic for a stack of content-addressable memory devices that share one data bus and one page/address bus. Each device holds three result flags: a local match, a local multiple match and a local full. Each flag joins its own daisy chain, which runs from the highest-priority device down to the lowest. The flags are loaded only when an active-low cycle enable returns high. Match and multiple match load at the end of a compare cycle. Full loads at the end of a write cycle. From the loaded flags the chains settle combinationally, with one gate level of delay per device.

The node also produces the enable for the shared buses. A device may drive the buses only when it holds the highest-priority match in the whole stack. It must also be in a cycle that reads the top result or the status, and the external output enable must be asserted. The operation code of a cycle is captured when the enable falls. A cycle that does not touch the result flags, such as a control-register write, therefore runs without disturbing a chain that is still settling. The CAM array and the compare engine that supply the local indications are outside this block.

Top module: `cam_cascade_node`

## Requirements
- R1: After a synchronous reset, the match, multiple-match and full flags are clear, `match_out` and `multi_out` follow only their chain inputs, `full_out` is low, and `bus_drive` is low.
- R2: `match_out` is the OR of `match_in` and the device's match flag.
- R3: `multi_out` is high when `multi_in` is high, when the device's multiple-match flag is set, or when the device's match flag is set while `match_in` is high.
- R4: `full_out` is the AND of `full_in` and the device's full flag. With the first device's `full_in` tied high, the stack reads full only when every device is full.
- R5: The match and multiple-match flags load from `loc_match` and `loc_multi` at the clock edge that first samples `en_n` high after a cycle whose captured operation is compare (code 1). They hold their value while `en_n` stays low.
- R6: The full flag loads from `loc_full` at the clock edge that first samples `en_n` high after a cycle whose captured operation is write (code 2).
- R7: Other operations leave flags unchanged. A cycle with code 0 (other) or code 3 (read top result) leaves all three flags unchanged. A compare leaves the full flag unchanged, and a write leaves the match and multiple-match flags unchanged.
- R8: `bus_drive` is high only while a read-top cycle (code 3) is in progress, that is, from the edge that samples `en_n` low until the edge that samples it high again. It also requires the match flag to be set, `match_in` to be low and `oe_n` to be low.
- R9: The operation code is captured at the edge that first samples `en_n` low. A change of `op` later in the same cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low cycle enable |
| op | input | 2 | Operation code: 0 other, 1 compare, 2 write, 3 read top result |
| oe_n | input | 1 | Active-low external output enable |
| loc_match | input | 1 | Local match from the compare engine |
| loc_multi | input | 1 | Local multiple match from the compare engine |
| loc_full | input | 1 | Local full indication from the array |
| match_in | input | 1 | Match chain from the higher-priority neighbour |
| multi_in | input | 1 | Multiple-match chain from the higher-priority neighbour |
| full_in | input | 1 | Full chain from the higher-priority neighbour |
| match_out | output | 1 | Match chain to the lower-priority neighbour |
| multi_out | output | 1 | Multiple-match chain to the lower-priority neighbour |
| full_out | output | 1 | Full chain to the lower-priority neighbour |
| bus_drive | output | 1 | Enable for the shared data and address buses |

## Verification
The bench chains four nodes with the default package encodings. The first node's match and multiple-match inputs are tied low and its full input is tied high. With four nodes in the chain, the bench can exercise single winners at both ends, two devices matching at once (which produces a cascade-derived multiple match), a stack that is full in all but one device, and a stack that is full in all devices. Each of the four `bus_drive` lines is compared against the single expected winner. Mid-cycle samples confirm that flags hold while the enable is low. An opcode change made late in a cycle confirms that the operation is captured when the enable falls.

// File: rtl/casc_pkg.sv
package casc_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_OTHER    = 2'd0,
        OP_COMPARE  = 2'd1,
        OP_WRITE    = 2'd2,
        OP_READ_TOP = 2'd3
    } casc_op_e;

    typedef struct packed {
        logic match;
        logic multi;
        logic full;
    } casc_flags_t;

    localparam casc_flags_t FLAGS_CLEAR = '{match: 1'b0, multi: 1'b0, full: 1'b0};

    // One link of the three chains: upstream values combined with local flags.
    function automatic casc_flags_t link_eval(input casc_flags_t up, input casc_flags_t loc);
        casc_flags_t dn;
        dn.match = up.match | loc.match;
        dn.multi = up.multi | loc.multi | (loc.match & up.match);
        dn.full  = up.full & loc.full;
        return dn;
    endfunction

endpackage

// File: rtl/casc_cycle_ctl.sv
module casc_cycle_ctl
    import casc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_n,
    input  casc_op_e op,
    output casc_op_e op_q,
    output logic     active,
    output logic     rise
);
    logic en_n_q;
    logic fall;

    assign fall = !en_n && en_n_q;
    assign rise = en_n && !en_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_n_q <= 1'b1;
            op_q   <= OP_OTHER;
            active <= 1'b0;
        end else begin
            en_n_q <= en_n;
            if (fall) begin
                op_q   <= op;
                active <= 1'b1;
            end else if (rise) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/casc_flag_bank.sv
module casc_flag_bank
    import casc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  casc_op_e    op_q,
    input  casc_flags_t loc,
    output casc_flags_t flags
);
    logic load_cmp;
    logic load_wr;

    assign load_cmp = rise && (op_q == OP_COMPARE);
    assign load_wr  = rise && (op_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_CLEAR;
        end else begin
            if (load_cmp) begin
                flags.match <= loc.match;
                flags.multi <= loc.multi;
            end
            if (load_wr) begin
                flags.full <= loc.full;
            end
        end
    end
endmodule

// File: rtl/casc_chain_link.sv
module casc_chain_link
    import casc_pkg::*;
(
    input  casc_flags_t up,
    input  casc_flags_t flags,
    output casc_flags_t dn,
    output logic        winner
);
    assign dn     = link_eval(up, flags);
    assign winner = flags.match && !up.match;
endmodule

// File: rtl/cam_cascade_node.sv
module cam_cascade_node
    import casc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en_n,
    input  logic [OP_W-1:0] op,
    input  logic            oe_n,
    input  logic            loc_match,
    input  logic            loc_multi,
    input  logic            loc_full,
    input  logic            match_in,
    input  logic            multi_in,
    input  logic            full_in,
    output logic            match_out,
    output logic            multi_out,
    output logic            full_out,
    output logic            bus_drive
);
    casc_op_e    op_q;
    logic        active;
    logic        rise;
    logic        winner;
    casc_flags_t loc_s;
    casc_flags_t flags;
    casc_flags_t up_s;
    casc_flags_t dn_s;

    assign loc_s = '{match: loc_match, multi: loc_multi, full: loc_full};
    assign up_s  = '{match: match_in, multi: multi_in, full: full_in};

    casc_cycle_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .en_n   (en_n),
        .op     (casc_op_e'(op)),
        .op_q   (op_q),
        .active (active),
        .rise   (rise)
    );

    casc_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .op_q  (op_q),
        .loc   (loc_s),
        .flags (flags)
    );

    casc_chain_link u_link (
        .up     (up_s),
        .flags  (flags),
        .dn     (dn_s),
        .winner (winner)
    );

    assign match_out = dn_s.match;
    assign multi_out = dn_s.multi;
    assign full_out  = dn_s.full;
    assign bus_drive = active && (op_q == OP_READ_TOP) && winner && !oe_n;
endmodule

// File: rtl/cam_cascade_node_chk.sv
module cam_cascade_node_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_n,
    input logic       oe_n,
    input logic       match_in,
    input logic       multi_in,
    input logic       full_in,
    input logic       match_out,
    input logic       multi_out,
    input logic       full_out,
    input logic       bus_drive,
    input logic [2:0] flag_vec
);
    AST_DRIVE_NEEDS_TOP: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (!match_in && !oe_n && match_out)); // R8
    AST_MATCH_PASSES: assert property (@(posedge clk) disable iff (rst)
        match_in |-> match_out); // R2
    AST_MULTI_PASSES: assert property (@(posedge clk) disable iff (rst)
        multi_in |-> multi_out); // R3
    AST_FULL_NEEDS_UP: assert property (@(posedge clk) disable iff (rst)
        full_out |-> full_in); // R4
    AST_FLAGS_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> $stable(flag_vec)); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flag_vec == 3'b000)); // R1
endmodule

bind cam_cascade_node cam_cascade_node_chk chk (
    .clk       (clk),
    .rst       (rst),
    .en_n      (en_n),
    .oe_n      (oe_n),
    .match_in  (match_in),
    .multi_in  (multi_in),
    .full_in   (full_in),
    .match_out (match_out),
    .multi_out (multi_out),
    .full_out  (full_out),
    .bus_drive (bus_drive),
    .flag_vec  (flags)
);

// File: tb/cam_cascade_node_test.sv
`timescale 1ns/1ps
module cam_cascade_node_test;
    localparam int NDEV = 4;
    localparam logic [1:0] C_OTH = 2'd0;
    localparam logic [1:0] C_CMP = 2'd1;
    localparam logic [1:0] C_WR  = 2'd2;
    localparam logic [1:0] C_RD  = 2'd3;
    localparam int NVEC = 7;
    // {loc_match[3:0], loc_multi[3:0], sys_match, sys_multi, drive[3:0]}; bit i = device i, device 0 highest priority
    localparam logic [13:0] VEC [NVEC] = '{
        {4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000},
        {4'b0100, 4'b0000, 1'b1, 1'b0, 4'b0100},
        {4'b0110, 4'b0000, 1'b1, 1'b1, 4'b0010},
        {4'b1000, 4'b1000, 1'b1, 1'b1, 4'b1000},
        {4'b0001, 4'b0000, 1'b1, 1'b0, 4'b0001},
        {4'b1111, 4'b0000, 1'b1, 1'b1, 4'b0001},
        {4'b0000, 4'b0010, 1'b0, 1'b1, 4'b0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n = 1'b1;
    logic [1:0] op = C_OTH;
    logic oe_n = 1'b1;
    logic [NDEV-1:0] lm = '0, lmm = '0, lf = '0;
    logic [NDEV:0] mch, mul, ful;
    logic [NDEV-1:0] drv;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign mch[0] = 1'b0;
    assign mul[0] = 1'b0;
    assign ful[0] = 1'b1;

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        cam_cascade_node uut (
            .clk(clk), .rst(rst), .en_n(en_n), .op(op), .oe_n(oe_n),
            .loc_match(lm[g]), .loc_multi(lmm[g]), .loc_full(lf[g]),
            .match_in(mch[g]), .multi_in(mul[g]), .full_in(ful[g]),
            .match_out(mch[g+1]), .multi_out(mul[g+1]), .full_out(ful[g+1]),
            .bus_drive(drv[g])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One enable cycle: op_a at the falling enable, op_b driven afterwards.
    task automatic run_cycle(input logic [1:0] op_a, input logic [1:0] op_b, input logic oe_lv,
                             output logic [NDEV-1:0] drv_mid, output logic match_mid);
        @(negedge clk); en_n = 1'b0; op = op_a; oe_n = oe_lv;
        @(negedge clk); op = op_b;
        @(negedge clk); drv_mid = drv; match_mid = mch[NDEV];
        en_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [NDEV-1:0] dm;
        logic mm;
        logic prev_match;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 match", mch[NDEV], 0);
        check("R1 multi", mul[NDEV], 0);
        check("R1 full", ful[NDEV], 0);
        check("R1 drive", drv, 0);

        prev_match = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            lm = VEC[i][13:10];
            lmm = VEC[i][9:6];
            run_cycle(C_CMP, C_CMP, 1'b1, dm, mm);
            check("R5 hold while enable low", mm, prev_match);
            check("R2 system match", mch[NDEV], VEC[i][5]);
            check("R3 system multi", mul[NDEV], VEC[i][4]);
            prev_match = VEC[i][5];
            lm = '0; lmm = '0;
            run_cycle(C_RD, C_RD, 1'b0, dm, mm);
            check("R8 drive winner", dm, VEC[i][3:0]);
            check("R8 drive after cycle", drv, 0);
            check("R7 read keeps match", mch[NDEV], VEC[i][5]);
        end

        // Full chain
        lf = 4'b0111;
        run_cycle(C_WR, C_WR, 1'b1, dm, mm);
        check("R4 partial full", ful[NDEV], 0);
        check("R6 upper devices full", ful[3], 1);
        lf = 4'b1111;
        run_cycle(C_WR, C_WR, 1'b1, dm, mm);
        check("R4 all full", ful[NDEV], 1);
        check("R7 write keeps match", mch[NDEV], 0);
        check("R7 write keeps multi", mul[NDEV], 1);
        lf = 4'b0000; lm = 4'b0100;
        run_cycle(C_CMP, C_CMP, 1'b1, dm, mm);
        check("R7 compare keeps full", ful[NDEV], 1);
        check("R5 compare loads", mch[NDEV], 1);
        lm = 4'b0001; lf = 4'b0000;
        run_cycle(C_OTH, C_OTH, 1'b1, dm, mm);
        check("R7 other keeps match", drv, 0);
        check("R7 other keeps full", ful[NDEV], 1);
        lm = '0;
        run_cycle(C_RD, C_RD, 1'b0, dm, mm);
        check("R7 other keeps winner", dm, 4'b0100);
        lf = 4'b1110;
        run_cycle(C_WR, C_WR, 1'b1, dm, mm);
        check("R4 first device not full", ful[NDEV], 0);

        // Drive gating
        run_cycle(C_RD, C_RD, 1'b1, dm, mm);
        check("R8 no drive with oe_n high", dm, 0);
        run_cycle(C_OTH, C_OTH, 1'b0, dm, mm);
        check("R8 no drive outside read", dm, 0);

        // Late opcode change: read captured, compare ignored
        lm = 4'b1000;
        run_cycle(C_RD, C_CMP, 1'b0, dm, mm);
        check("R9 captured read drives", dm, 4'b0100);
        check("R9 late compare ignored", drv, 0);
        run_cycle(C_RD, C_RD, 1'b0, dm, mm);
        check("R9 winner unchanged", dm, 4'b0100);
        lm = 4'b0000;
        run_cycle(C_CMP, C_OTH, 1'b1, dm, mm);
        check("R9 captured compare loads", mch[NDEV], 0);

        // Reset in the middle of a populated state
        lm = 4'b0001;
        run_cycle(C_CMP, C_CMP, 1'b1, dm, mm);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 match after reset", mch[NDEV], 0);
        check("R1 multi after reset", mul[NDEV], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule